// File: doc/BRIEF.md
# Packet Receive Sequencer

This block is the control state machine of a spread-spectrum receiver. It steps the receiver through reception of one packet, in a fixed order. First it waits for the multi-phase clock to report lock. It then starts the estimation sub-units one after another: coarse frequency-offset estimation, spreading-code acquisition, multipath search and channel gain estimation. Each sub-unit gets a one-cycle start pulse and an enable level, and the sequencer waits on that unit's done flag before moving on. The sequencer does no signal processing of its own.

The sequencer counts symbol strobes against the packet layout. The preamble lasts 120 symbols, and all four estimation steps must finish inside it. An 8-symbol data-start field follows, which fixes the timing of the first payload symbol. The payload is 1024 symbols. The combiner is enabled from the start of the data-start field onward, so it only runs once the path gains exist. A data-valid window frames the payload exactly. If the preamble runs out before estimation ends, the packet is dropped and an error pulse is raised.

Top module: `pkt_rx_seq`

## Requirements
- R1: A synchronous reset, sampled high on a clock edge, returns the sequencer to the wait-for-lock state. It clears every enable, every start pulse, data-valid, end-of-packet and error.
- R2: In the wait-for-lock state, all enables stay low and done flags are ignored. A clock edge that samples lock_i high enters the frequency-offset phase.
- R3: The estimation phases run in a fixed order: frequency offset (unit 0), acquisition (unit 1), path search (unit 2), channel estimation (unit 3). A phase advances on the edge that samples its own done flag, est_done_i[k] for unit k. Done flags of units that are not active have no effect. unit_en_o[k] is high exactly while unit k's phase is active, and at most one enable is high.
- R4: On entry to the phase of unit k, unit_start_o[k] is high for exactly one cycle, and it rises together with unit_en_o[k].
- R5: Preamble symbols are counted from entry into the frequency-offset phase. If channel estimation finishes early, the sequencer holds with all enables low until the 120th strobe. On that strobe it enters the data-start field, raising unit_en_o[4] (combiner) with a one-cycle unit_start_o[4]. unit_en_o[4] stays high through the data-start field and the payload.
- R6: If the 120th preamble strobe arrives while any estimation phase is still unfinished, the sequencer returns to wait-for-lock. seq_err_o then pulses for one cycle, with all enables and data-valid low.
- R7: If channel estimation reports done on the same edge as the 120th preamble strobe, estimation counts as finished in time. The sequencer enters the data-start field directly, with no error.
- R8: After 8 data-start strobes, data_valid_o rises. It stays high for exactly 1024 symbol strobes and falls on the edge of the 1024th.
- R9: pkt_end_o pulses for one cycle, in the first cycle with data_valid_o low after the payload, and the sequencer is back in wait-for-lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_i | input | 1 | Multi-phase clock lock indication |
| sym_stb_i | input | 1 | One-cycle strobe per received symbol |
| est_done_i | input | 4 | Done flags: 0 offset, 1 acquisition, 2 path search, 3 channel estimation |
| unit_en_o | output | 5 | Phase enables; bit 4 is the combiner |
| unit_start_o | output | 5 | One-cycle start pulses, same bit order as unit_en_o |
| data_valid_o | output | 1 | High across the 1024-symbol payload |
| pkt_end_o | output | 1 | One-cycle end-of-packet pulse |
| seq_err_o | output | 1 | One-cycle pulse when the preamble budget expires |

## Verification
Two events can fall in the same cycle: the channel-estimation done flag and the strobe that ends the preamble budget. Depending on how that tie is resolved, the packet either goes on to the data-start field or is aborted. The bench creates this tie on purpose. On two packets its channel-estimation responder stays silent until it drives done in the very cycle it issues the 120th strobe. Those packets must run to end-of-packet with 1024 valid strobes and no error pulse. Packets whose responder never answers must instead end in the error pulse.

// File: rtl/pkt_rx_seq_pkg.sv
package pkt_rx_seq_pkg;

  localparam int N_EST  = 4;
  localparam int N_UNIT = N_EST + 1;
  localparam int RAKE_U = N_EST;

  typedef enum logic [2:0] {
    ST_WAIT  = 3'd0,
    ST_CFO   = 3'd1,
    ST_ACQ   = 3'd2,
    ST_PATH  = 3'd3,
    ST_CHEST = 3'd4,
    ST_HOLD  = 3'd5,
    ST_SFD   = 3'd6,
    ST_DATA  = 3'd7
  } seq_state_t;

  // True when a count sits on the last symbol of a field of length len
  function automatic logic at_last(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

  function automatic logic in_preamble(input seq_state_t s);
    return (s == ST_CFO) || (s == ST_ACQ) || (s == ST_PATH) ||
           (s == ST_CHEST) || (s == ST_HOLD);
  endfunction

  // Done flag of the unit owning the current phase (0 when none owns it)
  function automatic logic own_done(input seq_state_t s, input logic [N_EST-1:0] d);
    case (s)
      ST_CFO:   return d[0];
      ST_ACQ:   return d[1];
      ST_PATH:  return d[2];
      ST_CHEST: return d[3];
      default:  return 1'b0;
    endcase
  endfunction

  // Enable pattern per state
  function automatic logic [N_UNIT-1:0] unit_enable(input seq_state_t s);
    logic [N_UNIT-1:0] e;
    e = '0;
    case (s)
      ST_CFO:          e[0] = 1'b1;
      ST_ACQ:          e[1] = 1'b1;
      ST_PATH:         e[2] = 1'b1;
      ST_CHEST:        e[3] = 1'b1;
      ST_SFD, ST_DATA: e[RAKE_U] = 1'b1;
      default:         e = '0;
    endcase
    return e;
  endfunction

  // Start pulse raised when moving from one state into another
  function automatic logic [N_UNIT-1:0] entry_pulse(input seq_state_t from,
                                                    input seq_state_t to);
    logic [N_UNIT-1:0] p;
    p = '0;
    if (from != to) begin
      case (to)
        ST_CFO:   p[0] = 1'b1;
        ST_ACQ:   p[1] = 1'b1;
        ST_PATH:  p[2] = 1'b1;
        ST_CHEST: p[3] = 1'b1;
        ST_SFD:   p[RAKE_U] = 1'b1;
        default:  p = '0;
      endcase
    end
    return p;
  endfunction

  // States whose entry starts a fresh symbol count
  function automatic logic restarts_count(input seq_state_t to);
    return (to == ST_CFO) || (to == ST_SFD) || (to == ST_DATA);
  endfunction

endpackage

// File: rtl/prs_sym_cnt.sv
module prs_sym_cnt #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/prs_pulse_reg.sv
module prs_pulse_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end

endmodule

// File: rtl/prs_phase_fsm.sv
module prs_phase_fsm
  import pkt_rx_seq_pkg::*;
#(
  parameter int PRE_SYMS = 120,
  parameter int SFD_SYMS = 8,
  parameter int PAY_SYMS = 1024,
  parameter int CNT_W    = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock,
  input  logic             strobe,
  input  logic [N_EST-1:0] est_done,
  input  logic [CNT_W-1:0] sym_cnt,
  output seq_state_t       state_q,
  output seq_state_t       state_d,
  output logic             pre_end,
  output logic             abort_ev,
  output logic             pay_end
);

  logic cur_done;
  logic sfd_end;

  assign cur_done = own_done(state_q, est_done);
  assign pre_end  = strobe && in_preamble(state_q) && at_last(32'(sym_cnt), PRE_SYMS);
  assign sfd_end  = strobe && (state_q == ST_SFD)  && at_last(32'(sym_cnt), SFD_SYMS);
  assign pay_end  = strobe && (state_q == ST_DATA) && at_last(32'(sym_cnt), PAY_SYMS);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_WAIT: begin
        if (lock) state_d = ST_CFO;
      end
      ST_CFO, ST_ACQ, ST_PATH: begin
        if (pre_end)       state_d = ST_WAIT;
        else if (cur_done) state_d = seq_state_t'(state_q + 3'd1);
      end
      ST_CHEST: begin
        // done on the last preamble strobe still counts as in time
        if (cur_done)     state_d = pre_end ? ST_SFD : ST_HOLD;
        else if (pre_end) state_d = ST_WAIT;
      end
      ST_HOLD: begin
        if (pre_end) state_d = ST_SFD;
      end
      ST_SFD: begin
        if (sfd_end) state_d = ST_DATA;
      end
      ST_DATA: begin
        if (pay_end) state_d = ST_WAIT;
      end
      default: state_d = ST_WAIT;
    endcase
  end

  assign abort_ev = pre_end && (state_d == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/pkt_rx_seq.sv
module pkt_rx_seq
  import pkt_rx_seq_pkg::*;
#(
  parameter int PRE_SYMS = 120,
  parameter int SFD_SYMS = 8,
  parameter int PAY_SYMS = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_i,
  input  logic              sym_stb_i,
  input  logic [N_EST-1:0]  est_done_i,
  output logic [N_UNIT-1:0] unit_en_o,
  output logic [N_UNIT-1:0] unit_start_o,
  output logic              data_valid_o,
  output logic              pkt_end_o,
  output logic              seq_err_o
);

  localparam int MAX_AB  = (PRE_SYMS > SFD_SYMS) ? PRE_SYMS : SFD_SYMS;
  localparam int MAX_LEN = (MAX_AB > PAY_SYMS) ? MAX_AB : PAY_SYMS;
  localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

  seq_state_t        state_q;
  seq_state_t        state_d;
  logic [CNT_W-1:0]  sym_cnt;
  logic              phase_change;
  logic              cnt_clr;
  logic              cnt_inc;
  logic              pre_end;
  logic              abort_ev;
  logic              pay_end;
  logic [N_UNIT-1:0] start_d;
  logic [1:0]        flag_d;
  logic [1:0]        flag_q;

  assign phase_change = (state_d != state_q);
  assign cnt_clr      = phase_change && restarts_count(state_d);
  assign cnt_inc      = sym_stb_i && (state_q != ST_WAIT);
  assign start_d      = entry_pulse(state_q, state_d);
  assign flag_d       = {abort_ev, pay_end};

  prs_phase_fsm #(
    .PRE_SYMS (PRE_SYMS),
    .SFD_SYMS (SFD_SYMS),
    .PAY_SYMS (PAY_SYMS),
    .CNT_W    (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .lock     (lock_i),
    .strobe   (sym_stb_i),
    .est_done (est_done_i),
    .sym_cnt  (sym_cnt),
    .state_q  (state_q),
    .state_d  (state_d),
    .pre_end  (pre_end),
    .abort_ev (abort_ev),
    .pay_end  (pay_end)
  );

  prs_sym_cnt #(
    .W (CNT_W)
  ) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (cnt_inc),
    .cnt (sym_cnt)
  );

  prs_pulse_reg #(
    .W (N_UNIT)
  ) u_start (
    .clk (clk),
    .rst (rst),
    .d   (start_d),
    .q   (unit_start_o)
  );

  prs_pulse_reg #(
    .W (2)
  ) u_flags (
    .clk (clk),
    .rst (rst),
    .d   (flag_d),
    .q   (flag_q)
  );

  assign seq_err_o    = flag_q[1];
  assign pkt_end_o    = flag_q[0];
  assign unit_en_o    = unit_enable(state_q);
  assign data_valid_o = (state_q == ST_DATA);

endmodule

// File: rtl/pkt_rx_seq_chk.sv
module pkt_rx_seq_chk
  import pkt_rx_seq_pkg::*;
#(
  parameter int PAY_SYMS = 1024
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe,
  input logic [N_UNIT-1:0] en,
  input logic [N_UNIT-1:0] start,
  input logic              valid,
  input logic              eop,
  input logic              err
);

  int vcnt;

  always_ff @(posedge clk) begin
    if (rst || !valid) begin
      vcnt <= 0;
    end else if (strobe) begin
      vcnt <= vcnt + 1;
    end
  end

  AST_EN_ONEHOT:     assert property (@(posedge clk) disable iff (rst) $onehot0(en)); // R3
  AST_START_ONEHOT:  assert property (@(posedge clk) disable iff (rst) $onehot0(start)); // R4
  AST_START_IN_EN:   assert property (@(posedge clk) disable iff (rst) (start & ~en) == '0); // R4
  AST_START_FRESH:   assert property (@(posedge clk) disable iff (rst) (|start) |=> ((start & $past(start)) == '0)); // R4
  AST_VALID_RAKE:    assert property (@(posedge clk) disable iff (rst) valid |-> en[RAKE_U]); // R5
  AST_ERR_IDLE:      assert property (@(posedge clk) disable iff (rst) err |-> (en == '0 && !valid)); // R6
  AST_EOP_COUNT:     assert property (@(posedge clk) disable iff (rst) eop |-> (vcnt == PAY_SYMS)); // R8
  AST_EOP_FALL:      assert property (@(posedge clk) disable iff (rst) eop |-> (!valid && $past(valid))); // R9
  AST_EOP_SINGLE:    assert property (@(posedge clk) disable iff (rst) eop |=> !eop); // R9

endmodule

bind pkt_rx_seq pkt_rx_seq_chk #(.PAY_SYMS(PAY_SYMS)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .strobe (sym_stb_i),
  .en     (unit_en_o),
  .start  (unit_start_o),
  .valid  (data_valid_o),
  .eop    (pkt_end_o),
  .err    (seq_err_o)
);

// File: tb/pkt_rx_seq_bench.sv
module pkt_rx_seq_bench;

  localparam int PRE = 120;
  localparam int SFD = 8;
  localparam int PAY = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lock_i = 1'b0;
  logic       sym_stb_i = 1'b0;
  logic [3:0] est_done_i = '0;
  logic [4:0] unit_en_o;
  logic [4:0] unit_start_o;
  logic       data_valid_o;
  logic       pkt_end_o;
  logic       seq_err_o;

  always #4 clk = ~clk;

  pkt_rx_seq u_pkt_rx_seq (
    .clk          (clk),
    .rst          (rst),
    .lock_i       (lock_i),
    .sym_stb_i    (sym_stb_i),
    .est_done_i   (est_done_i),
    .unit_en_o    (unit_en_o),
    .unit_start_o (unit_start_o),
    .data_valid_o (data_valid_o),
    .pkt_end_o    (pkt_end_o),
    .seq_err_o    (seq_err_o)
  );

  int total = 0;
  int bad = 0;

  // stimulus configuration, written by the scenario process
  int cfg_per = 2;
  int cfg_dly [4];
  int cfg_kind = 0;   // 0 normal, 1 abort early unit, 2 collide, 3 abort at channel estimation
  int go_req = 0;
  bit rst_req = 1'b1;

  // observation and responder state, written by the cycle process
  int  go_ack = 0;
  int  n_eop = 0;
  int  n_err = 0;
  int  vcnt = 0;
  int  cyc = 0;
  bit  wd = 1'b0;
  int  cd [4];
  int  per_cnt = 0;
  bit  armed = 1'b0;
  int  post_rst = 0;

  // expected-behaviour model: phase code 0 wait,1..4 estimation,5 hold,6 data-start,7 payload
  int         m_ph = 0;
  int         m_cnt = 0;
  logic [4:0] m_start = '0;
  bit         m_err = 1'b0;
  bit         m_eop = 1'b0;

  function automatic logic [4:0] exp_en(input int ph);
    logic [4:0] e;
    e = '0;
    if (ph >= 1 && ph <= 4) e[ph-1] = 1'b1;
    if (ph == 6 || ph == 7) e[4] = 1'b1;
    return e;
  endfunction

  function automatic logic [4:0] exp_start(input int from, input int to);
    logic [4:0] s;
    s = '0;
    if (from != to) begin
      if (to >= 1 && to <= 4) s[to-1] = 1'b1;
      if (to == 6) s[4] = 1'b1;
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin
      cd[k] = -1;
      cfg_dly[k] = 0;
    end
  end

  always @(negedge clk) begin
    logic [3:0] dn;
    bit st;
    bit lk;
    int nph;
    string t_en;
    cyc++;

    // ---- compare outputs against the model
    if (armed && !wd) begin
      if (post_rst > 0) begin
        check(unit_en_o == 5'd0 && unit_start_o == 5'd0 && !data_valid_o && !pkt_end_o && !seq_err_o,
              "R1", "outputs after reset", int'({unit_en_o, unit_start_o}), 0);
        post_rst--;
      end
      t_en = (m_ph == 0) ? "R2" : "R3";
      check(unit_en_o[3:0] === exp_en(m_ph)[3:0], t_en, "estimation enables",
            int'(unit_en_o[3:0]), int'(exp_en(m_ph)[3:0]));
      check(unit_en_o[4] === exp_en(m_ph)[4], "R5", "combiner enable",
            int'(unit_en_o[4]), int'(exp_en(m_ph)[4]));
      check(unit_start_o[3:0] === m_start[3:0], "R4", "start pulses",
            int'(unit_start_o[3:0]), int'(m_start[3:0]));
      check(unit_start_o[4] === m_start[4], "R5", "combiner start",
            int'(unit_start_o[4]), int'(m_start[4]));
      check(data_valid_o === (m_ph == 7), "R8", "data valid",
            int'(data_valid_o), int'(m_ph == 7));
      check(pkt_end_o === m_eop, "R9", "end of packet", int'(pkt_end_o), int'(m_eop));
      check(seq_err_o === m_err, "R6", "error pulse", int'(seq_err_o), int'(m_err));
      if (pkt_end_o === 1'b1) begin
        n_eop++;
        check(vcnt == PAY, "R8", "strobes inside valid window", vcnt, PAY);
      end
      if (seq_err_o === 1'b1) n_err++;
      for (int k = 0; k < 4; k++) begin
        if (unit_start_o[k] === 1'b1) cd[k] = (cfg_kind == 2 && k == 3) ? -1 : cfg_dly[k];
      end
    end

    if (cyc > 190000 && !wd) begin
      wd = 1'b1;
      check(1'b0, "R9", "watchdog expired", cyc, 190000);
    end

    // ---- drive inputs for the next edge
    rst = rst_req;
    per_cnt++;
    st = 1'b0;
    if (per_cnt >= cfg_per) begin
      st = 1'b1;
      per_cnt = 0;
    end
    if (data_valid_o === 1'b1 && st) vcnt++;
    dn = '0;
    for (int k = 0; k < 4; k++) begin
      if (cd[k] == 0) begin
        dn[k] = 1'b1;
        cd[k] = -1;
      end else if (cd[k] > 0) begin
        cd[k]--;
      end
    end
    if (cfg_kind == 2 && m_ph == 4 && st && m_cnt == PRE - 1) dn[3] = 1'b1;
    if ($urandom % 8 == 0) begin
      int j;
      j = int'($urandom % 4);
      if (j != m_ph - 1) dn[j] = 1'b1;
    end
    if (m_ph == 0) lk = (go_req != go_ack) && ($urandom % 4 == 0);
    else           lk = ($urandom % 2 == 1);
    lock_i = lk;
    sym_stb_i = st;
    est_done_i = dn;

    // ---- advance the model to the state after the next edge
    if (rst_req) begin
      armed = 1'b1;
      post_rst = 1;
      m_ph = 0; m_cnt = 0; m_start = '0; m_err = 1'b0; m_eop = 1'b0;
      for (int k = 0; k < 4; k++) cd[k] = -1;
    end else begin
      bit last_pre;
      last_pre = st && m_ph >= 1 && m_ph <= 5 && m_cnt == PRE - 1;
      nph = m_ph;
      m_err = 1'b0;
      m_eop = 1'b0;
      case (m_ph)
        0: if (lk) nph = 1;
        1, 2, 3: begin
          if (last_pre) begin nph = 0; m_err = 1'b1; end
          else if (dn[m_ph-1]) nph = m_ph + 1;
        end
        4: begin
          if (dn[3]) nph = last_pre ? 6 : 5;
          else if (last_pre) begin nph = 0; m_err = 1'b1; end
        end
        5: if (last_pre) nph = 6;
        6: if (st && m_cnt == SFD - 1) nph = 7;
        7: if (st && m_cnt == PAY - 1) begin nph = 0; m_eop = 1'b1; end
        default: nph = 0;
      endcase
      m_start = exp_start(m_ph, nph);
      if (nph != m_ph && (nph == 1 || nph == 6 || nph == 7)) m_cnt = 0;
      else if (m_ph != 0 && st) m_cnt++;
      if (m_ph == 0 && nph == 1) begin
        go_ack = go_req;
        vcnt = 0;
      end
      m_ph = nph;
    end
  end

  initial begin
    int seed_v;
    int e0;
    int p0;
    seed_v = int'($urandom(32'd20250307));
    rst_req = 1'b1;
    repeat (3) @(posedge clk);
    rst_req = 1'b0;
    repeat (4) @(posedge clk);

    for (int p = 0; p < 10; p++) begin
      if (p == 2 || p == 8)      cfg_kind = 1;
      else if (p == 3 || p == 7) cfg_kind = 2;
      else if (p == 5)           cfg_kind = 3;
      else                       cfg_kind = 0;
      cfg_per = (p == 0) ? 1 : 2 + int'($urandom % 3);
      for (int k = 0; k < 4; k++) cfg_dly[k] = (p == 1) ? 0 : int'($urandom % 21);
      if (cfg_kind == 1) cfg_dly[$urandom % 3] = -1;
      if (cfg_kind == 3) cfg_dly[3] = -1;
      e0 = n_err;
      p0 = n_eop;
      go_req++;
      while (n_eop == p0 && n_err == e0 && !wd) @(posedge clk);
      repeat (2) @(posedge clk);
      if (cfg_kind == 1 || cfg_kind == 3) begin
        check(n_err == e0 + 1 && n_eop == p0, "R6", "expired preamble aborts", n_err - e0, 1);
      end else if (cfg_kind == 2) begin
        check(n_err == e0 && n_eop == p0 + 1, "R7", "done on last preamble strobe", n_err - e0, 0);
      end else begin
        check(n_eop == p0 + 1 && n_err == e0, "R9", "packet completes", n_eop - p0, 1);
      end
      repeat (5) @(posedge clk);
    end

    // reset in the middle of a payload
    cfg_kind = 0;
    cfg_per = 2;
    for (int k = 0; k < 4; k++) cfg_dly[k] = 3;
    go_req++;
    repeat (600) @(posedge clk);
    rst_req = 1'b1;
    repeat (3) @(posedge clk);
    rst_req = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(unit_en_o == 5'd0 && !data_valid_o, "R1", "idle after mid-packet reset",
          int'(unit_en_o), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule